// File: doc/BRIEF.md
# Hybrid Ring-and-Counter Pulse-Width Modulator

This block produces a fixed-frequency pulse train whose high time is set by an 8-bit duty command. It does not run a single fast counter through all 256 steps. The fine five bits of timing come from a single token that moves around a 32-stage one-hot ring, advancing one stage per fast clock. The coarse three bits come from a small counter that steps once each time the token completes a revolution. A switching period therefore lasts 8 revolutions, or 256 stage steps. The output goes high at the start of each period. It goes low when the coarse counter matches the upper three bits of the duty value and the token sits on the ring tap selected by the lower five bits.

The duty command is captured once per period, at its start, and held to the range 8 to 249 (roughly 3.1% to 97.3%). A run input gates the token. While run is low, the token is placed back on stage 0, the counter is cleared and the output is held low. When run returns high, a new period starts on the first running clock. A one-clock tick marks every ring revolution so that the surrounding logic can use it as its slow clock enable.

Top module: `hybrid_dpwm`

## Requirements
- R1: While run is high, the output rises exactly once every 256 clocks, so the switching period is 256 stage steps.
- R2: The tick output is a one-clock pulse that occurs once every 32 running clocks. It is high in the clock after the token leaves the last ring stage, which gives 8 ticks per period.
- R3: The output goes high on the clock edge at which the token is on stage 0 and the coarse counter is 0. That edge is the period start.
- R4: The output stays high for exactly D clocks per period, where D is the captured duty value: upper three bits are the coarse count, lower five bits are the ring tap.
- R5: A duty command below 8 is captured as 8, and a command above 249 is captured as 249. Values from 8 to 249 are captured unchanged.
- R6: The duty command is sampled only at the period start. A change in the middle of a period has no effect until the next period.
- R7: While run is low, the output and tick are low from the next clock onward, and the ring and counter return to their start position. The first running clock edge after run rises begins a new period.
- R8: After synchronous reset, the output and tick are low and the ring is at its start position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock; one period equals one ring stage delay |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | High lets the token circulate; low stops and re-seeds the ring |
| dutyIn | input | 8 | Duty command in 1/256 steps |
| pwmOut | output | 1 | Pulse-width modulated output |
| tick | output | 1 | One-clock pulse per ring revolution |

## Verification
Every result is registered once after the edge that causes it. The output rises in the clock after the period-start edge. It falls D clocks after it rose. The tick appears in the clock after the token wraps. Stopping takes effect one clock after run is sampled low.

The bench keeps a behavioural slot model that steps on each rising edge and applies these same one-edge delays. All outputs are compared against the model on the falling edge, well away from the edge that updates them. Directed measurements count high time and period length between observed edges, so any off-by-one clock offset shows up as a wrong count.

// File: rtl/hdpwm_pkg.sv
package hdpwm_pkg;

  // Strobes sent from the control module to the ring datapath
  typedef struct packed {
    logic advance;  // move the token one stage
    logic reseed;   // put the token back on stage 0, clear the output
    logic setOut;   // period start: raise the output
    logic clrOut;   // duty reached: lower the output
  } strobe_t;

endpackage

// File: rtl/hdpwm_ring.sv
module hdpwm_ring
  import hdpwm_pkg::*;
#(
  parameter int RING_STAGES = 32,
  localparam int FINE_BITS = $clog2(RING_STAGES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  strobe_t              strobes,
  input  logic [FINE_BITS-1:0] fineSel,
  output logic                 atStart,
  output logic                 lastStage,
  output logic                 tapHit,
  output logic                 pwmOut,
  output logic                 tick
);

  logic [RING_STAGES-1:0] tokenRing;
  logic                   outQ;
  logic                   tickQ;

  // One-hot token ring; each stage hands the token to the next
  always_ff @(posedge clk) begin
    if (rst || strobes.reseed) begin
      tokenRing <= RING_STAGES'(1);
    end else if (strobes.advance) begin
      tokenRing <= {tokenRing[RING_STAGES-2:0], tokenRing[RING_STAGES-1]};
    end
  end

  assign atStart   = tokenRing[0];
  assign lastStage = tokenRing[RING_STAGES-1];
  assign tapHit    = tokenRing[fineSel];

  // Output set/reset latch and revolution tick
  always_ff @(posedge clk) begin
    if (rst || strobes.reseed) begin
      outQ  <= 1'b0;
      tickQ <= 1'b0;
    end else begin
      tickQ <= strobes.advance && lastStage;
      if (strobes.setOut) begin
        outQ <= 1'b1;
      end else if (strobes.clrOut) begin
        outQ <= 1'b0;
      end
    end
  end

  assign pwmOut = outQ;
  assign tick   = tickQ;

  // R7
  token_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(tokenRing) == 1);

  // R7
  reseed_home_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.reseed |=> (tokenRing[0] && !outQ && !tickQ));

  // R3
  period_rise_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.setOut |=> outQ);

  // R4
  duty_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (strobes.clrOut && !strobes.setOut && !strobes.reseed) |=> !outQ);

endmodule

// File: rtl/hdpwm_ctrl.sv
module hdpwm_ctrl
  import hdpwm_pkg::*;
#(
  parameter int RING_STAGES = 32,
  parameter int CNT_BITS    = 3,
  parameter int DUTY_MIN    = 8,
  parameter int DUTY_MAX    = 249,
  localparam int FINE_BITS = $clog2(RING_STAGES),
  localparam int DUTY_BITS = CNT_BITS + FINE_BITS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 run,
  input  logic [DUTY_BITS-1:0] dutyIn,
  input  logic                 atStart,
  input  logic                 lastStage,
  input  logic                 tapHit,
  output strobe_t              strobes,
  output logic [FINE_BITS-1:0] fineSel
);

  localparam logic [DUTY_BITS-1:0] MIN_V = DUTY_BITS'(DUTY_MIN);
  localparam logic [DUTY_BITS-1:0] MAX_V = DUTY_BITS'(DUTY_MAX);

  logic [CNT_BITS-1:0]  coarseCnt;
  logic [DUTY_BITS-1:0] dutyQ;
  logic [DUTY_BITS-1:0] dutyClamped;
  logic                 periodStart;
  logic                 coarseMatch;

  always_comb begin
    if (dutyIn < MIN_V) begin
      dutyClamped = MIN_V;
    end else if (dutyIn > MAX_V) begin
      dutyClamped = MAX_V;
    end else begin
      dutyClamped = dutyIn;
    end
  end

  assign periodStart = atStart && (coarseCnt == '0);
  assign coarseMatch = (coarseCnt == dutyQ[DUTY_BITS-1:FINE_BITS]);
  assign fineSel     = dutyQ[FINE_BITS-1:0];

  always_comb begin
    strobes.advance = run;
    strobes.reseed  = !run;
    strobes.setOut  = run && periodStart;
    strobes.clrOut  = run && !periodStart && coarseMatch && tapHit;
  end

  // Coarse counter steps once per revolution
  always_ff @(posedge clk) begin
    if (rst || !run) begin
      coarseCnt <= '0;
    end else if (lastStage) begin
      coarseCnt <= coarseCnt + 1'b1;
    end
  end

  // Duty captured only at the period start
  always_ff @(posedge clk) begin
    if (rst) begin
      dutyQ <= MIN_V;
    end else if (run && periodStart) begin
      dutyQ <= dutyClamped;
    end
  end

  // R5
  duty_range_chk: assert property (@(posedge clk) disable iff (rst)
    (dutyQ >= MIN_V) && (dutyQ <= MAX_V));

  // R6
  duty_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(run && periodStart) |=> $stable(dutyQ));

  // R7
  cnt_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> (coarseCnt == '0));

endmodule

// File: rtl/hybrid_dpwm.sv
module hybrid_dpwm
  import hdpwm_pkg::*;
#(
  parameter int RING_STAGES = 32,
  parameter int CNT_BITS    = 3,
  parameter int DUTY_MIN    = 8,
  parameter int DUTY_MAX    = 249,
  localparam int FINE_BITS = $clog2(RING_STAGES),
  localparam int DUTY_BITS = CNT_BITS + FINE_BITS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 run,
  input  logic [DUTY_BITS-1:0] dutyIn,
  output logic                 pwmOut,
  output logic                 tick
);

  strobe_t              strobes;
  logic [FINE_BITS-1:0] fineSel;
  logic                 atStart;
  logic                 lastStage;
  logic                 tapHit;

  hdpwm_ctrl #(
    .RING_STAGES(RING_STAGES),
    .CNT_BITS   (CNT_BITS),
    .DUTY_MIN   (DUTY_MIN),
    .DUTY_MAX   (DUTY_MAX)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .dutyIn   (dutyIn),
    .atStart  (atStart),
    .lastStage(lastStage),
    .tapHit   (tapHit),
    .strobes  (strobes),
    .fineSel  (fineSel)
  );

  hdpwm_ring #(
    .RING_STAGES(RING_STAGES)
  ) u_ring (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .fineSel  (fineSel),
    .atStart  (atStart),
    .lastStage(lastStage),
    .tapHit   (tapHit),
    .pwmOut   (pwmOut),
    .tick     (tick)
  );

  // R2
  tick_idle_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

endmodule

// File: tb/tb_hybrid_dpwm.sv
module tb_hybrid_dpwm;

  localparam int CLK_PERIOD = 10;
  localparam int PERIOD     = 256;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       run = 1'b0;
  logic [7:0] dutyIn = 8'd0;
  logic       pwmOut;
  logic       tick;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // behavioural reference state
  int slot = 0;
  int dutyLat = 8;
  bit outExp = 1'b0;
  bit tickExp = 1'b0;

  hybrid_dpwm dut (
    .clk   (clk),
    .rst   (rst),
    .run   (run),
    .dutyIn(dutyIn),
    .pwmOut(pwmOut),
    .tick  (tick)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int clampDuty(int d);
    if (d < 8) return 8;
    if (d > 249) return 249;
    return d;
  endfunction

  task automatic check(bit ok, string req, int actual, int expected);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, actual, expected, cycles);
    end
  endtask

  // Reference model: one step per rising edge
  always @(posedge clk) begin
    if (rst || !run) begin
      slot = 0;
      outExp = 1'b0;
      tickExp = 1'b0;
      if (rst) dutyLat = 8;
    end else begin
      tickExp = ((slot % 32) == 31);
      if (slot == 0) begin
        outExp = 1'b1;
        dutyLat = clampDuty(int'(dutyIn));
      end else if (slot == dutyLat) begin
        outExp = 1'b0;
      end
      slot = (slot + 1) % PERIOD;
    end
  end

  // Per-clock comparison away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      check(pwmOut == outExp, "R3/R4 output vs model", int'(pwmOut), int'(outExp));
      check(tick == tickExp, "R2 tick vs model", int'(tick), int'(tickExp));
    end
    if (cycles > WATCHDOG) begin
      check(1'b0, "watchdog", cycles, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // Wait for the next rising edge, then measure high time and full period
  task automatic measure(int expHigh, string req);
    int hi = 0;
    int lo = 0;
    while (pwmOut) @(negedge clk);
    while (!pwmOut) @(negedge clk);
    while (pwmOut) begin hi++; @(negedge clk); end
    while (!pwmOut) begin lo++; @(negedge clk); end
    check(hi == expHigh, req, hi, expHigh);
    check(hi + lo == PERIOD, "R1 period length", hi + lo, PERIOD);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R8 reset state
    check(pwmOut == 1'b0, "R8 output low in reset", int'(pwmOut), 0);
    check(tick == 1'b0, "R8 tick low in reset", int'(tick), 0);
    rst = 1'b0;
    @(negedge clk);
    check(pwmOut == 1'b0, "R8 output low after reset, stopped", int'(pwmOut), 0);

    // R3: first running edge starts a period
    dutyIn = 8'd100;
    run = 1'b1;
    @(negedge clk);
    check(pwmOut == 1'b1, "R3 rise after first running edge", int'(pwmOut), 1);

    measure(100, "R4 high time duty 100");
    dutyIn = 8'd37;   measure(37,  "R4 high time duty 37");
    dutyIn = 8'd200;  measure(200, "R4 high time duty 200");
    dutyIn = 8'd31;   measure(31,  "R4 coarse 0 fine 31");
    dutyIn = 8'd32;   measure(32,  "R4 coarse 1 fine 0");
    dutyIn = 8'd0;    measure(8,   "R5 clamp low from 0");
    dutyIn = 8'd7;    measure(8,   "R5 clamp low from 7");
    dutyIn = 8'd8;    measure(8,   "R5 minimum passes unchanged");
    dutyIn = 8'd255;  measure(249, "R5 clamp high from 255");
    dutyIn = 8'd250;  measure(249, "R5 clamp high from 250");
    dutyIn = 8'd249;  measure(249, "R5 maximum passes unchanged");

    // R2: ticks per period
    begin
      int nTicks = 0;
      for (int i = 0; i < PERIOD; i++) begin
        @(negedge clk);
        if (tick) nTicks++;
      end
      check(nTicks == 8, "R2 ticks per period", nTicks, 8);
    end

    // R6: change in mid-period is ignored until the next period
    dutyIn = 8'd100;
    measure(100, "R6 setup duty 100");
    while (!pwmOut) @(negedge clk);
    repeat (20) @(negedge clk);
    dutyIn = 8'd200;
    begin
      int hi = 20;
      while (pwmOut) begin hi++; @(negedge clk); end
      check(hi == 100, "R6 mid-period change ignored", hi, 100);
    end
    measure(200, "R6 new duty in next period");

    // R7: stop and restart
    @(negedge clk);
    run = 1'b0;
    @(negedge clk);
    check(pwmOut == 1'b0, "R7 output low when stopped", int'(pwmOut), 0);
    begin
      int seen = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (pwmOut || tick) seen++;
      end
      check(seen == 0, "R7 no activity while stopped", seen, 0);
    end
    dutyIn = 8'd60;
    run = 1'b1;
    @(negedge clk);
    check(pwmOut == 1'b1, "R7 restart begins period", int'(pwmOut), 1);
    begin
      int hi = 1;
      @(negedge clk);
      while (pwmOut) begin hi++; @(negedge clk); end
      check(hi == 60, "R7 first period after restart", hi, 60);
    end
    measure(60, "R7 steady after restart");

    repeat (5) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule